// File: doc/BRIEF.md
# Self-Correcting Decade Counter

This block is a four-bit synchronous counter that steps through the decimal digits 0 to 9 and then returns to 0. Each next-state bit is set by a fixed XOR equation on the present state, not by a table lookup. Because of this, the six codes above 9 still have a defined successor, and the counter finds its own way back into the decimal range after an upset.

A terminal flag is decoded combinationally from the stored bits, so it rises in the same cycle as the digit 9. A synchronous active-high clear starts the counter at zero. A debug load port writes any four-bit value into the state register, which lets a testbench or a scan routine place the counter in an illegal code and watch it recover.

The state bits appear on `cnt_q` with the following weights:
- bit 3 has weight 8
- bit 2 has weight 4
- bit 1 has weight 2
- bit 0 has weight 1

Top module: `bcd_decade_counter`

## Requirements
- R1: While `clr` is high at a rising edge, `cnt_q` becomes 4'b0000 after that edge. The clear wins over `dbg_load`.
- R2: With `clr` and `dbg_load` low and `cnt_q` between 0 and 8, each edge adds one to the value. The value 9 (4'b1001) goes to 0.
- R3: `term` equals `cnt_q[0] & cnt_q[3]` in the same cycle, with no register delay. Within the legal range it is high only at 9.
- R4: With `clr` and `dbg_load` low, an illegal code moves on one edge to a fixed successor:
  - 10 goes to 11
  - 11 goes to 6
  - 12 goes to 13
  - 13 goes to 4
  - 14 goes to 15
  - 15 goes to 2
- R5: Starting from any illegal code with `clr` and `dbg_load` held low, `cnt_q` holds a value of 9 or less after at most two edges.
- R6: While `dbg_load` is high and `clr` is low at an edge, `cnt_q` takes `dbg_val` after that edge, in place of the counted value.
- R7: `term` is also high in the illegal codes 11, 13 and 15, and low in 10, 12 and 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to zero, active high, highest priority |
| dbg_load | input | 1 | Debug load strobe, active high |
| dbg_val | input | 4 | Value written into the state on a debug load |
| cnt_q | output | 4 | Present state, bit 3 weight 8 down to bit 0 weight 1 |
| term | output | 1 | Terminal flag, combinational decode of the state |

## Verification
The following are checked by assertions on every cycle:
- the clear
- the debug load
- the legal increment and the wrap from 9
- the fixed successor of each illegal code
- the two-edge recovery bound, tracked by a counter of consecutive illegal cycles
- the implication that a high flag has bits 3 and 0 set

Only the bench's scenarios can show that each of the six illegal codes is actually reached and leaves along its stated path. They also show that the flag is low in every state where it should be, and that a long run of counting repeats the decade with no drift.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
  localparam int DIGIT_W    = 4;
  localparam int LAST_DIGIT = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // Next state from the XOR equations. Bit 3 has weight 8 and bit 0 has weight 1.
  function automatic digit_t xor_step(digit_t s);
    digit_t n;
    n[0] = ~s[0];
    n[1] = s[1] ^ (s[0] & ~s[3]);
    n[2] = s[2] ^ (s[0] & s[1]);
    n[3] = s[3] ^ ((s[0] & s[3]) | (s[0] & s[1] & s[2]));
    return n;
  endfunction

  function automatic logic code_legal(digit_t s);
    return (int'(s) <= LAST_DIGIT);
  endfunction

  function automatic logic term_of(digit_t s);
    return s[0] & s[3];
  endfunction

  // Successor of each illegal code, written as a table for the checkers.
  function automatic digit_t stray_next(digit_t s);
    case (s)
      4'd10:   return 4'd11;
      4'd11:   return 4'd6;
      4'd12:   return 4'd13;
      4'd13:   return 4'd4;
      4'd14:   return 4'd15;
      4'd15:   return 4'd2;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/bcd_next_logic.sv
module bcd_next_logic
  import bcd_ctr_pkg::*;
(
  input  digit_t cur,
  output digit_t nxt,
  output logic   wrap_evt
);
  assign nxt      = xor_step(cur);
  // Flags the step from 9 back to 0.
  assign wrap_evt = (cur == digit_t'(LAST_DIGIT));
endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg
  import bcd_ctr_pkg::*;
(
  input  logic   clk,
  input  logic   clr,
  input  logic   load_en,
  input  digit_t load_val,
  input  digit_t nxt,
  output digit_t q
);
  always_ff @(posedge clk) begin
    if (clr)          q <= '0;
    else if (load_en) q <= load_val;
    else              q <= nxt;
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) clr |=> (q == '0));

  // R6
  dbg_load_chk: assert property (@(posedge clk) disable iff (clr)
    load_en |=> (q == $past(load_val)));
endmodule

// File: rtl/bcd_term_decode.sv
module bcd_term_decode
  import bcd_ctr_pkg::*;
(
  input  digit_t cur,
  output logic   term
);
  assign term = term_of(cur);

  // R3
  always_comb begin
    term_bits_chk: assert (!term || (cur[3] && cur[0]));
  end
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
  import bcd_ctr_pkg::*;
(
  input  logic               clk,
  input  logic               clr,
  input  logic               dbg_load,
  input  logic [DIGIT_W-1:0] dbg_val,
  output logic [DIGIT_W-1:0] cnt_q,
  output logic               term
);
  digit_t state_q;
  digit_t state_nxt;
  logic   wrap_evt;
  logic   stray_now;
  logic   [1:0] stray_run;

  bcd_next_logic u_next (
    .cur      (state_q),
    .nxt      (state_nxt),
    .wrap_evt (wrap_evt)
  );

  bcd_state_reg u_reg (
    .clk      (clk),
    .clr      (clr),
    .load_en  (dbg_load),
    .load_val (dbg_val),
    .nxt      (state_nxt),
    .q        (state_q)
  );

  bcd_term_decode u_term (
    .cur  (state_q),
    .term (term)
  );

  assign cnt_q     = state_q;
  assign stray_now = !code_legal(state_q);

  // Counts the edges taken from illegal codes since the last clear or load.
  always_ff @(posedge clk) begin
    if (clr || dbg_load)           stray_run <= '0;
    else if (stray_now)            stray_run <= (stray_run == 2'd3) ? 2'd3 : stray_run + 2'd1;
    else                           stray_run <= '0;
  end

  // R2
  legal_step_chk: assert property (@(posedge clk) disable iff (clr)
    (!dbg_load && !stray_now && !wrap_evt) |=> (cnt_q == $past(cnt_q) + 4'd1));

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (clr)
    (!dbg_load && wrap_evt) |=> (cnt_q == 4'd0));

  // R4
  stray_path_chk: assert property (@(posedge clk) disable iff (clr)
    (!dbg_load && stray_now) |=> (cnt_q == stray_next($past(cnt_q))));

  // R5
  recover_bound_chk: assert property (@(posedge clk) disable iff (clr)
    (stray_run == 2'd2) |-> !stray_now);
endmodule

// File: tb/bcd_decade_counter_tb.sv
module bcd_decade_counter_tb;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       dbg_load = 1'b0;
  logic [3:0] dbg_val = 4'd0;
  logic [3:0] cnt_q;
  logic       term;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_decade_counter u_dut (
    .clk      (clk),
    .clr      (clr),
    .dbg_load (dbg_load),
    .dbg_val  (dbg_val),
    .cnt_q    (cnt_q),
    .term     (term)
  );

  // Reference successor, built from the requirements.
  function automatic logic [3:0] ref_next(logic [3:0] v);
    if (v < 4'd9)  return v + 4'd1;
    if (v == 4'd9) return 4'd0;
    case (v)
      4'd10: return 4'd11;  4'd11: return 4'd6;
      4'd12: return 4'd13;  4'd13: return 4'd4;
      4'd14: return 4'd15;  default: return 4'd2;
    endcase
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    clr = 1'b1; step(); step();
    chk("R1 reset value", cnt_q, 4'd0);
    chk("R3 flag at reset", {3'b0, term}, 4'd0);
    clr = 1'b0;
  endtask

  task automatic t_count();
    logic [3:0] e = 4'd0;
    for (int i = 0; i < 25; i++) begin
      step();
      e = ref_next(e);
      chk("R2 count sequence", cnt_q, e);
      chk("R3 flag at digit", {3'b0, term}, {3'b0, e == 4'd9});
    end
  endtask

  task automatic t_stray();
    for (int c = 10; c < 16; c++) begin
      logic [3:0] v = 4'(c);
      int edges = 0;
      dbg_load = 1'b1; dbg_val = v; step(); dbg_load = 1'b0;
      chk("R6 load illegal", cnt_q, v);
      chk("R7 flag in illegal code", {3'b0, term}, {3'b0, v[0] & v[3]});
      step();
      chk("R4 illegal successor", cnt_q, ref_next(v));
      edges = 1;
      while (cnt_q > 4'd9 && edges < 4) begin step(); edges++; end
      chk("R5 recovery edges within two", (edges <= 2) ? 4'd1 : 4'd0, 4'd1);
    end
  endtask

  task automatic t_clr_priority();
    dbg_load = 1'b1; dbg_val = 4'd12; clr = 1'b1; step();
    chk("R1 clear beats load", cnt_q, 4'd0);
    dbg_load = 1'b0; clr = 1'b0;
  endtask

  task automatic t_load_override();
    step(); step(); step();
    chk("R2 count from zero", cnt_q, 4'd3);
    dbg_load = 1'b1; dbg_val = 4'd7; step(); dbg_load = 1'b0;
    chk("R6 load overrides count", cnt_q, 4'd7);
    step(); step();
    chk("R2 count after load", cnt_q, 4'd9);
    chk("R3 flag at nine", {3'b0, term}, 4'd1);
    step();
    chk("R2 wrap to zero", cnt_q, 4'd0);
  endtask

  initial begin
    t_reset();
    t_count();
    t_stray();
    t_clr_priority();
    t_load_override();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule